// File: doc/BRIEF.md
# Interrupt Destination Resolver and Dispatcher

This block accepts one interrupt delivery request per cycle and turns it into per-CPU actions for up to `NCPU` processors. A request names a destination ID, says whether that ID is physical or logical, selects a delivery mode and carries a vector, a trigger-level bit and the number of the input pin that raised it. The block compares the destination with every CPU's physical ID or logical ID, which arrive on input buses, and builds a target bitmask from the result.

The bitmask is then dispatched according to the delivery mode. Fixed mode pulses an interrupt-set strobe to every CPU in the mask. Lowest-priority mode picks one CPU by rotating round-robin. NMI mode raises sticky per-CPU NMI-pending flags and gives a one-cycle kick only to CPUs whose flag was clear.

A timer-override input steers pin-0 deliveries to CPU 0 alone. All outputs are registered and appear one cycle after the request is sampled.

Top module: `intDestDispatch`

## Requirements
- R1: In physical mode (`reqLogical`=0), destination all-ones (0xFF) selects every CPU.
- R2: In physical mode with any other destination, only the lowest-numbered CPU whose physical ID equals the destination is selected.
- R3: In logical mode, destination 0 selects no CPU. Otherwise, CPU i is selected when the bitwise AND of its logical ID and the destination is nonzero.
- R4: A request whose target mask is empty is dropped: no interrupt-set strobe, no NMI kick, and the round-robin position is unchanged.
- R5: Fixed mode (`reqMode`=3'b000) drives `intSet` equal to the target mask for one cycle, the cycle after the request. In that cycle `intVector` and `intLevel` carry the request's vector and trigger bit.
- R6: Lowest-priority mode (`reqMode`=3'b001) sets exactly one `intSet` bit: the first mask bit found searching upward (wrapping) from the CPU after the last one chosen. After reset the search starts at CPU 0.
- R7: NMI mode (`reqMode`=3'b100) ORs the target mask into `nmiPending`. `nmiKick` pulses only for selected CPUs whose flag was clear before the request. An `nmiClear` bit clears a flag, but a set in the same cycle wins.
- R8: When `timerOverride`=1 and `reqPin`=0, a non-empty fixed or lowest-priority request strobes CPU 0 only and leaves the round-robin position unchanged. Requests from other pins are dispatched normally.
- R9: Any other `reqMode` encoding is ignored: `intSet`, `nmiKick` and `nmiPending` are unaffected.
- R10: After reset, `intSet`, `intVector`, `intLevel`, `nmiPending` and `nmiKick` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is presented this cycle |
| reqDest | input | ID_W | Destination ID |
| reqLogical | input | 1 | 0 = physical destination, 1 = logical destination |
| reqMode | input | 3 | Delivery mode: 000 fixed, 001 lowest priority, 100 NMI |
| reqVector | input | VEC_W | Interrupt vector |
| reqLevel | input | 1 | Trigger mode passed to the CPU (1 = level) |
| reqPin | input | PIN_W | Source pin number of the request |
| timerOverride | input | 1 | Steer pin-0 fixed/lowest deliveries to CPU 0 |
| cpuPhysIds | input | NCPU*ID_W | Physical ID of CPU i in bits [i*ID_W +: ID_W] |
| cpuLogIds | input | NCPU*ID_W | Logical ID of CPU i in bits [i*ID_W +: ID_W] |
| nmiClear | input | NCPU | Per-CPU clear of the NMI-pending flag |
| intSet | output | NCPU | One-cycle interrupt-set strobes |
| intVector | output | VEC_W | Vector of the last delivery |
| intLevel | output | 1 | Trigger mode of the last delivery |
| nmiPending | output | NCPU | Sticky NMI-pending flags |
| nmiKick | output | NCPU | One-cycle strobe for each newly pending NMI |

## Verification
The hardest state to reach is the interaction of the round-robin position with dropped and overridden requests. These requests must leave the position untouched, and this is visible only through the CPU chosen by a later lowest-priority request. The stimulus runs a rotation over a three-CPU logical group. It inserts an empty lowest-priority request and a pin-0 override request between picks, then checks that the next ordinary pick continues the rotation. NMI flags are driven through a set, a clear and a simultaneous clear-and-set, so that kick suppression for already-pending CPUs shows at the ports.

// File: rtl/intDispPkg.sv
package intDispPkg;

  localparam logic [2:0] MODE_FIXED  = 3'b000;
  localparam logic [2:0] MODE_LOWEST = 3'b001;
  localparam logic [2:0] MODE_NMI    = 3'b100;

  // Strobes from control to datapath, one request per cycle
  typedef struct packed {
    logic sendAll;   // fixed delivery to the whole mask
    logic sendOne;   // round-robin pick from the mask
    logic raiseNmi;  // OR mask into NMI-pending flags
    logic onlyCpu0;  // timer override: CPU 0 alone
  } dispStrobes_t;

endpackage

// File: rtl/destMatch.sv
module destMatch #(
  parameter int NCPU = 8,
  parameter int ID_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ID_W-1:0]      dest,
  input  logic                 logical,
  input  logic [NCPU*ID_W-1:0] physIds,
  input  logic [NCPU*ID_W-1:0] logIds,
  output logic [NCPU-1:0]      mask
);

  localparam logic [ID_W-1:0] BCAST = '1;

  logic [ID_W-1:0] physArr [NCPU];
  logic [ID_W-1:0] logArr  [NCPU];

  genvar g;
  generate
    for (g = 0; g < NCPU; g++) begin : gSlice
      assign physArr[g] = physIds[g*ID_W +: ID_W];
      assign logArr[g]  = logIds[g*ID_W +: ID_W];
    end
  endgenerate

  logic found;

  always_comb begin
    mask  = '0;
    found = 1'b0;
    if (!logical) begin
      if (dest == BCAST) begin
        mask = '1;
      end else begin
        for (int i = 0; i < NCPU; i++) begin
          if (!found && physArr[i] == dest) begin
            mask[i] = 1'b1;
            found   = 1'b1;
          end
        end
      end
    end else if (dest != '0) begin
      for (int i = 0; i < NCPU; i++) begin
        mask[i] = |(logArr[i] & dest);
      end
    end
  end

  AST_BCAST_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (!logical && dest == BCAST) |-> (&mask)); // R1
  AST_PHYS_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (!logical && dest != BCAST) |-> $onehot0(mask)); // R2
  AST_LOGICAL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (logical && dest == '0) |-> (mask == '0)); // R3

endmodule

// File: rtl/dispCtrl.sv
module dispCtrl
  import intDispPkg::*;
#(
  parameter int PIN_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [2:0]       reqMode,
  input  logic [PIN_W-1:0] reqPin,
  input  logic             timerOverride,
  input  logic             maskEmpty,
  output dispStrobes_t     strb
);

  logic live, steer, isFixed, isLowest, isNmi;

  always_comb begin
    live     = reqValid && !maskEmpty;
    steer    = timerOverride && (reqPin == '0);
    isFixed  = (reqMode == MODE_FIXED);
    isLowest = (reqMode == MODE_LOWEST);
    isNmi    = (reqMode == MODE_NMI);

    strb          = '0;
    strb.sendAll  = live && isFixed && !steer;
    strb.sendOne  = live && isLowest && !steer;
    strb.raiseNmi = live && isNmi;
    strb.onlyCpu0 = live && (isFixed || isLowest) && steer;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb)); // R9
  AST_EMPTY_NOSTROBE: assert property (@(posedge clk) disable iff (!rstN)
    maskEmpty |-> (strb == '0)); // R4

endmodule

// File: rtl/dispDatapath.sv
module dispDatapath
  import intDispPkg::*;
#(
  parameter int NCPU  = 8,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dispStrobes_t     strb,
  input  logic [NCPU-1:0]  mask,
  input  logic [VEC_W-1:0] vector,
  input  logic             level,
  input  logic [NCPU-1:0]  nmiClear,
  output logic [NCPU-1:0]  intSet,
  output logic [VEC_W-1:0] intVector,
  output logic             intLevel,
  output logic [NCPU-1:0]  nmiPending,
  output logic [NCPU-1:0]  nmiKick
);

  localparam int PTR_W = (NCPU > 1) ? $clog2(NCPU) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NCPU - 1);

  logic [PTR_W-1:0] lastPick;
  logic [PTR_W-1:0] pickIdx;
  logic [NCPU-1:0]  pickOh;
  logic             hit;
  logic             deliver;

  // Round-robin search starting after the last chosen CPU
  always_comb begin
    pickIdx = lastPick;
    pickOh  = '0;
    hit     = 1'b0;
    for (int off = 1; off <= NCPU; off++) begin
      int idx;
      idx = (int'(lastPick) + off) % NCPU;
      if (!hit && mask[idx]) begin
        hit         = 1'b1;
        pickIdx     = PTR_W'(idx);
        pickOh[idx] = 1'b1;
      end
    end
  end

  assign deliver = strb.sendAll || strb.sendOne || strb.onlyCpu0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intSet     <= '0;
      intVector  <= '0;
      intLevel   <= 1'b0;
      nmiPending <= '0;
      nmiKick    <= '0;
      lastPick   <= PTR_LAST;
    end else begin
      if (strb.sendAll)       intSet <= mask;
      else if (strb.sendOne)  intSet <= pickOh;
      else if (strb.onlyCpu0) intSet <= NCPU'(1);
      else                    intSet <= '0;

      if (deliver) begin
        intVector <= vector;
        intLevel  <= level;
      end
      if (strb.sendOne) lastPick <= pickIdx;

      nmiKick    <= strb.raiseNmi ? (mask & ~nmiPending) : '0;
      nmiPending <= (nmiPending & ~nmiClear) | (strb.raiseNmi ? mask : '0);
    end
  end

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rstN)
    strb.sendOne |=> ($countones(intSet) == 1)); // R6
  AST_CPU0_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    strb.onlyCpu0 |=> (intSet == NCPU'(1))); // R8
  AST_KICK_ONLY_NEW: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((nmiKick & $past(nmiPending)) == '0)); // R7
  AST_NMI_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(nmiPending) & ~$past(nmiClear)) & ~nmiPending) == '0)); // R7
  AST_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (strb == '0) |=> (intSet == '0 && nmiKick == '0)); // R9
  AST_FIXED_MASK: assert property (@(posedge clk) disable iff (!rstN)
    strb.sendAll |=> (intSet == $past(mask))); // R5

endmodule

// File: rtl/intDestDispatch.sv
module intDestDispatch
  import intDispPkg::*;
#(
  parameter int NCPU  = 8,
  parameter int ID_W  = 8,
  parameter int VEC_W = 8,
  parameter int PIN_W = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [ID_W-1:0]      reqDest,
  input  logic                 reqLogical,
  input  logic [2:0]           reqMode,
  input  logic [VEC_W-1:0]     reqVector,
  input  logic                 reqLevel,
  input  logic [PIN_W-1:0]     reqPin,
  input  logic                 timerOverride,
  input  logic [NCPU*ID_W-1:0] cpuPhysIds,
  input  logic [NCPU*ID_W-1:0] cpuLogIds,
  input  logic [NCPU-1:0]      nmiClear,
  output logic [NCPU-1:0]      intSet,
  output logic [VEC_W-1:0]     intVector,
  output logic                 intLevel,
  output logic [NCPU-1:0]      nmiPending,
  output logic [NCPU-1:0]      nmiKick
);

  logic [NCPU-1:0] targetMask;
  dispStrobes_t    strb;

  destMatch #(.NCPU(NCPU), .ID_W(ID_W)) uMatch (
    .clk(clk), .rstN(rstN),
    .dest(reqDest), .logical(reqLogical),
    .physIds(cpuPhysIds), .logIds(cpuLogIds),
    .mask(targetMask)
  );

  dispCtrl #(.PIN_W(PIN_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqMode(reqMode), .reqPin(reqPin),
    .timerOverride(timerOverride), .maskEmpty(targetMask == '0),
    .strb(strb)
  );

  dispDatapath #(.NCPU(NCPU), .VEC_W(VEC_W)) uPath (
    .clk(clk), .rstN(rstN),
    .strb(strb), .mask(targetMask),
    .vector(reqVector), .level(reqLevel), .nmiClear(nmiClear),
    .intSet(intSet), .intVector(intVector), .intLevel(intLevel),
    .nmiPending(nmiPending), .nmiKick(nmiKick)
  );

endmodule

// File: tb/tb_intDestDispatch.sv
module tb_intDestDispatch;

  localparam int NCPU = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             reqValid = 1'b0;
  logic [7:0]       reqDest = '0;
  logic             reqLogical = 1'b0;
  logic [2:0]       reqMode = '0;
  logic [7:0]       reqVector = '0;
  logic             reqLevel = 1'b0;
  logic [4:0]       reqPin = 5'd3;
  logic             timerOverride = 1'b0;
  logic [63:0]      cpuPhysIds;
  logic [63:0]      cpuLogIds;
  logic [NCPU-1:0]  nmiClear = '0;
  logic [NCPU-1:0]  intSet;
  logic [7:0]       intVector;
  logic             intLevel;
  logic [NCPU-1:0]  nmiPending;
  logic [NCPU-1:0]  nmiKick;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  // Physical IDs 0x10+i, except CPU5 duplicates CPU2's 0x12; logical IDs one-hot
  always_comb begin
    for (int i = 0; i < NCPU; i++) begin
      cpuPhysIds[i*8 +: 8] = (i == 5) ? 8'h12 : 8'(8'h10 + i);
      cpuLogIds[i*8 +: 8]  = 8'(1 << i);
    end
  end

  intDestDispatch dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqDest(reqDest),
    .reqLogical(reqLogical), .reqMode(reqMode), .reqVector(reqVector),
    .reqLevel(reqLevel), .reqPin(reqPin), .timerOverride(timerOverride),
    .cpuPhysIds(cpuPhysIds), .cpuLogIds(cpuLogIds), .nmiClear(nmiClear),
    .intSet(intSet), .intVector(intVector), .intLevel(intLevel),
    .nmiPending(nmiPending), .nmiKick(nmiKick)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Present one request for one cycle; return at the negedge where its result is visible
  task automatic doReq(input logic [7:0] d, input logic lg, input logic [2:0] m,
                       input logic [7:0] v, input logic lv, input logic [NCPU-1:0] clr);
    @(negedge clk);
    reqValid = 1'b1; reqDest = d; reqLogical = lg; reqMode = m;
    reqVector = v; reqLevel = lv; nmiClear = clr;
    @(negedge clk);
    reqValid = 1'b0; nmiClear = '0;
  endtask

  // {dest, logical, mode, vector, expected intSet, requirement}
  localparam int NV = 9;
  localparam logic [31:0] VECS [NV] = '{
    {8'hFF, 1'b0, 3'd0, 8'h31, 8'hFF, 4'd1},  // R1 broadcast
    {8'h13, 1'b0, 3'd0, 8'h32, 8'h08, 4'd2},  // R2 single match
    {8'h12, 1'b0, 3'd0, 8'h33, 8'h04, 4'd2},  // R2 first of two matches
    {8'h55, 1'b0, 3'd0, 8'h34, 8'h00, 4'd4},  // R4 no match dropped
    {8'h00, 1'b1, 3'd0, 8'h35, 8'h00, 4'd3},  // R3 logical zero
    {8'h81, 1'b1, 3'd0, 8'h36, 8'h81, 4'd3},  // R3 logical AND
    {8'h3C, 1'b1, 3'd0, 8'h37, 8'h3C, 4'd5},  // R5 fixed to group
    {8'hFF, 1'b0, 3'd3, 8'h38, 8'h00, 4'd9},  // R9 reserved mode
    {8'hFF, 1'b1, 3'd7, 8'h39, 8'h00, 4'd9}   // R9 reserved mode
  };

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 intSet", 32'(intSet), 32'h0);
    chk("R10 intVector", 32'(intVector), 32'h0);
    chk("R10 intLevel", 32'(intLevel), 32'h0);
    chk("R10 nmiPending", 32'(nmiPending), 32'h0);
    chk("R10 nmiKick", 32'(nmiKick), 32'h0);
    rstN = 1'b1;

    for (int k = 0; k < NV; k++) begin
      logic [31:0] e;
      e = VECS[k];
      doReq(e[31:24], e[23], e[22:20], e[19:12], 1'b0, '0);
      chk($sformatf("R%0d table %0d intSet", e[3:0], k), 32'(intSet), 32'(e[11:4]));
      if (e[11:4] != 8'h00)
        chk($sformatf("R%0d table %0d intVector", e[3:0], k), 32'(intVector), 32'(e[19:12]));
      chk($sformatf("R%0d table %0d nmiKick", e[3:0], k), 32'(nmiKick), 32'h0);
    end

    // R6 round robin over CPUs 1,2,5 with an empty request between picks (R4)
    doReq(8'h26, 1'b1, 3'd1, 8'h40, 1'b0, '0);
    chk("R6 first pick", 32'(intSet), 32'h02);
    doReq(8'h00, 1'b1, 3'd1, 8'h41, 1'b0, '0);
    chk("R4 empty lowest", 32'(intSet), 32'h00);
    doReq(8'h26, 1'b1, 3'd1, 8'h42, 1'b0, '0);
    chk("R6 second pick keeps rotation", 32'(intSet), 32'h04);
    doReq(8'h26, 1'b1, 3'd1, 8'h43, 1'b0, '0);
    chk("R6 third pick", 32'(intSet), 32'h20);
    doReq(8'h26, 1'b1, 3'd1, 8'h44, 1'b0, '0);
    chk("R6 wrap pick", 32'(intSet), 32'h02);
    chk("R6 vector", 32'(intVector), 32'h44);

    // R8 timer override from pin 0
    timerOverride = 1'b1; reqPin = 5'd0;
    doReq(8'hFF, 1'b0, 3'd0, 8'h50, 1'b0, '0);
    chk("R8 fixed override", 32'(intSet), 32'h01);
    doReq(8'h26, 1'b1, 3'd1, 8'h51, 1'b0, '0);
    chk("R8 lowest override", 32'(intSet), 32'h01);
    reqPin = 5'd2;
    doReq(8'hFF, 1'b0, 3'd0, 8'h52, 1'b0, '0);
    chk("R8 other pin normal", 32'(intSet), 32'hFF);
    timerOverride = 1'b0;
    doReq(8'h26, 1'b1, 3'd1, 8'h53, 1'b0, '0);
    chk("R8 pointer untouched by override", 32'(intSet), 32'h04);

    // R7 NMI flags and kicks
    doReq(8'h05, 1'b1, 3'd4, 8'h00, 1'b0, '0);
    chk("R7 kick new", 32'(nmiKick), 32'h05);
    chk("R7 pending set", 32'(nmiPending), 32'h05);
    chk("R7 no intSet", 32'(intSet), 32'h00);
    doReq(8'h07, 1'b1, 3'd4, 8'h00, 1'b0, '0);
    chk("R7 kick only newly pending", 32'(nmiKick), 32'h02);
    chk("R7 pending grows", 32'(nmiPending), 32'h07);
    doReq(8'h00, 1'b1, 3'd7, 8'h00, 1'b0, 8'h01);
    chk("R7 clear", 32'(nmiPending), 32'h06);
    doReq(8'h02, 1'b1, 3'd4, 8'h00, 1'b0, 8'h02);
    chk("R7 set wins over clear", 32'(nmiPending), 32'h06);
    chk("R7 no kick when already pending", 32'(nmiKick), 32'h00);
    doReq(8'hFF, 1'b1, 3'd5, 8'h00, 1'b0, '0);
    chk("R9 reserved mode leaves NMI flags", 32'(nmiPending), 32'h06);
    chk("R9 reserved mode no kick", 32'(nmiKick), 32'h00);

    // R5 trigger bit carried
    doReq(8'h11, 1'b0, 3'd0, 8'h60, 1'b1, '0);
    chk("R5 level intSet", 32'(intSet), 32'h02);
    chk("R5 level bit", 32'(intLevel), 32'h1);
    chk("R5 level vector", 32'(intVector), 32'h60);
    @(negedge clk);
    chk("R5 strobe lasts one cycle", 32'(intSet), 32'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule